// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM Datapath

This block is a single-port synchronous memory. Each word holds four lanes of nine bits, so a word is 36 bits wide. An external burst sequencer supplies the address, and the block samples every command on the rising clock edge. A cycle with the chip enable high is either a write or a read. A write happens when the global write input is high, which stores the whole word. It also happens when the lane-write enable is high together with at least one lane select, which stores only the selected lanes. Every other enabled cycle is a read.

The read path has two latencies, chosen by a static strap. In flow-through mode the data from the array's read register goes straight to the output bus. In pipelined mode one more output register sits in the path. Cycles that are not reads are deselects, writes or sleep cycles, and they release the bus through the same pipeline depth as read data. This gives dual-cycle-deselect timing. The output enable and the sleep input act on the bus combinationally. Sleep also blocks every command and leaves the stored contents unchanged. A released bus is shown by `rdDrive` low with `rdData` at zero, which stands in for high impedance.

Top module: `ssram_core`

## Requirements
- R1: A cycle with chipEn and globalWr high, and sleep low, stores wrData into all four lanes at addr, whatever byteWrEn and byteSel are.
- R2: A cycle with chipEn and byteWrEn high, globalWr and sleep low, and byteSel not zero updates only the lanes whose byteSel bit is set. Lane i is wrData bits [9i+8:9i].
- R3: An enabled cycle with byteWrEn high but byteSel all zero (and globalWr low) writes nothing and is handled as a read of addr.
- R4: With pipeMode low, the word read by a command sampled at edge k is driven from just after edge k until edge k+1.
- R5: With pipeMode high, the word read by a command sampled at edge k is driven from just after edge k+1 until edge k+2.
- R6: Back-to-back read commands deliver one word per cycle in both modes. A four-beat burst therefore follows 2-1-1-1 timing in flow-through mode and 3-1-1-1 timing in pipelined mode.
- R7: A read issued in the cycle right after a write to the same address returns the newly written data.
- R8: A cycle that is not a read releases the bus with the same latency a read would have: after edge k in flow-through mode, and after edge k+1 in pipelined mode.
- R9: With outEn low, the bus is released at once, without a clock edge. Raising outEn again shows the pending word at once.
- R10: While sleep is high, commands store nothing and read nothing, the bus is released at once, and the stored contents are kept.
- R11: While and after reset, the bus is released until the first read reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control pipeline |
| pipeMode | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| chipEn | input | 1 | Command enable, sampled at the edge |
| addr | input | ADDR_W | Word address from the burst sequencer |
| byteWrEn | input | 1 | Lane-write enable |
| byteSel | input | 4 | Per-lane write selects |
| globalWr | input | 1 | Whole-word write |
| wrData | input | 36 | Write data, four 9-bit lanes |
| outEn | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Sleep request, active high |
| rdData | output | 36 | Read data, zero when released |
| rdDrive | output | 1 | High while the bus is driven |

## Verification
The bench keeps a reference queue that follows the model cycle by cycle and compares against it at every falling edge. Directed checks target the read latency in each mode. A design with the output register wired into the wrong mode would show data one cycle early or late. The checks also cover the release one and two edges after a deselect. Releasing on the next edge in pipelined mode would cut off the last beat of a burst.

The lane tests cover three cases. A global write must override lane selects that are only partly set. A lane write must leave its neighbouring lanes untouched. A lane-write enable with no lanes selected must turn into a read instead of a silent write. Further tests cover a read straight after a write, output enable toggled between clock edges, and a write attempted during sleep. A design that let that write through would return the new value once sleep ends.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [LANES-1:0] laneWe;    // per-lane array write
    logic             rdLaunch;  // capture array word into stage one
    logic             busDrive;  // aligned valid for the selected latency
    logic             selPipe;   // output taken from stage two
  } ctrlStrobe_t;
endpackage

// File: rtl/ssram_ctrl.sv
module ssram_ctrl
  import ssram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pipeMode,
  input  logic             chipEn,
  input  logic             byteWrEn,
  input  logic [LANES-1:0] byteSel,
  input  logic             globalWr,
  input  logic             sleep,
  output ctrlStrobe_t      strobe
);
  localparam int STAGES = 2;

  logic [LANES-1:0]  laneWe;
  logic              anyWrite;
  logic              doRead;
  logic [STAGES-1:0] validPipe;

  // write decode: global write wins over lane selects
  always_comb begin
    laneWe = '0;
    if (chipEn && !sleep) begin
      if (globalWr)      laneWe = '1;
      else if (byteWrEn) laneWe = byteSel;
    end
  end

  assign anyWrite = |laneWe;
  assign doRead   = chipEn && !sleep && !anyWrite;

  // deselects travel the same pipe as reads (valid low)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[STAGES-2:0], doRead};
  end

  assign strobe.laneWe   = laneWe;
  assign strobe.rdLaunch = doRead;
  assign strobe.selPipe  = pipeMode;
  assign strobe.busDrive = pipeMode ? validPipe[1] : validPipe[0];

  p_global_all_lanes_r1: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !sleep && globalWr) |-> (&strobe.laneWe && !strobe.rdLaunch));

  p_sleep_inert_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (strobe.laneWe == '0 && !strobe.rdLaunch));

  p_flow_latency_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLaunch && !pipeMode) |=> strobe.busDrive);

  p_pipe_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLaunch && pipeMode) |=> ##1 strobe.busDrive);

  p_pipe_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdLaunch && pipeMode) |=> ##1 !strobe.busDrive);
endmodule

// File: rtl/ssram_dpath.sv
module ssram_dpath
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] stageOne;
  logic [WORD_W-1:0] stageTwo;
  logic [WORD_W-1:0] outWord;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (strobe.laneWe[g]) laneMem[addr] <= wrData[g*LANE_W +: LANE_W];
      if (strobe.rdLaunch)  laneQ <= laneMem[addr];
    end

    assign stageOne[g*LANE_W +: LANE_W] = laneQ;
  end

  // output register used only in pipelined mode
  always_ff @(posedge clk) stageTwo <= stageOne;

  assign outWord = strobe.selPipe ? stageTwo : stageOne;
  assign rdDrive = outEn && !sleep && strobe.busDrive;
  assign rdData  = rdDrive ? outWord : '0;

  p_bus_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!outEn || sleep) |-> (!rdDrive && rdData == '0));
endmodule

// File: rtl/ssram_core.sv
module ssram_core
  import ssram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              chipEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              globalWr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              outEn,
  input  logic              sleep,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  ctrlStrobe_t strobe;

  ssram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .chipEn(chipEn),
    .byteWrEn(byteWrEn), .byteSel(byteSel), .globalWr(globalWr),
    .sleep(sleep), .strobe(strobe)
  );

  ssram_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .strobe(strobe),
    .outEn(outEn), .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
  );
endmodule

// File: tb/ssram_core_tb_top.sv
module ssram_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pipeMode = 1'b0;
  logic        chipEn = 1'b0;
  logic [7:0]  addr = '0;
  logic        byteWrEn = 1'b0;
  logic [3:0]  byteSel = '0;
  logic        globalWr = 1'b0;
  logic [35:0] wrData = '0;
  logic        outEn = 1'b1;
  logic        sleep = 1'b0;
  logic [35:0] rdData;
  logic        rdDrive;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;
  string curReq = "R11";

  // reference queue
  logic [35:0] shadow [256];
  logic        mV1 = 1'b0, mV2 = 1'b0;
  logic [35:0] mD1 = '0, mD2 = '0;

  always #5 clk = ~clk;

  ssram_core dut_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .chipEn(chipEn), .addr(addr),
    .byteWrEn(byteWrEn), .byteSel(byteSel), .globalWr(globalWr), .wrData(wrData),
    .outEn(outEn), .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
  );

  function automatic logic [35:0] pat(input int a);
    return (36'(a) * 36'd2654435761) ^ 36'hA5A5_A5A5A;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBus(input string req, input logic expDrv, input logic [35:0] expData);
    chk({req, " drive"}, 36'(rdDrive), 36'(expDrv));
    chk({req, " data"}, rdData, expDrv ? expData : 36'h0);
  endtask

  task automatic autoCompare();
    logic drv;
    drv = outEn && !sleep && (pipeMode ? mV2 : mV1);
    chkBus({curReq, " ref"}, drv, pipeMode ? mD2 : mD1);
  endtask

  task automatic tick();
    logic isWr, isRd;
    logic [35:0] m;
    @(posedge clk);
    isWr = chipEn && !sleep && (globalWr || (byteWrEn && byteSel != 0));
    isRd = chipEn && !sleep && !isWr;
    mV2 = mV1; mD2 = mD1;
    mV1 = isRd;
    if (isRd) mD1 = shadow[addr];
    if (isWr) begin
      m = '0;
      for (int l = 0; l < 4; l++) if (globalWr || byteSel[l]) m[l*9 +: 9] = '1;
      shadow[addr] = (shadow[addr] & ~m) | (wrData & m);
    end
    @(negedge clk);
    autoCompare();
  endtask

  task automatic setIdle();
    chipEn = 0; globalWr = 0; byteWrEn = 0; byteSel = 0;
  endtask

  task automatic idle(input int n);
    setIdle();
    repeat (n) tick();
  endtask

  task automatic doWrite(input int a, input logic [35:0] d);
    chipEn = 1; globalWr = 1; byteWrEn = 0; byteSel = 0; addr = 8'(a); wrData = d;
    tick();
  endtask

  task automatic doRead(input int a);
    chipEn = 1; globalWr = 0; byteWrEn = 0; byteSel = 0; addr = 8'(a);
    tick();
  endtask

  task automatic setMode(input logic p);
    idle(2);
    pipeMode = p;
    idle(2);
  endtask

  task automatic testFlowBurst();
    curReq = "R4";
    setMode(0);
    for (int a = 0; a < 16; a++) doWrite(a, pat(a));
    idle(1);
    chkBus("R8 idle before burst", 0, 0);
    doRead(0); chkBus("R4 first beat after edge k", 1, pat(0));
    curReq = "R6";
    doRead(1); chkBus("R6 flow beat 2", 1, pat(1));
    doRead(2); chkBus("R6 flow beat 3", 1, pat(2));
    doRead(3); chkBus("R6 flow beat 4", 1, pat(3));
    setIdle(); tick(); chkBus("R8 flow release after edge k", 0, 0);
  endtask

  task automatic testGlobalOverride();
    curReq = "R1";
    chipEn = 1; globalWr = 1; byteWrEn = 1; byteSel = 4'b0101; addr = 8'd6;
    wrData = 36'h1_2345_6789;
    tick();
    doRead(6); chkBus("R1 global write all lanes", 1, 36'h1_2345_6789);
    idle(1);
  endtask

  task automatic testLaneWrite();
    logic [35:0] exp;
    curReq = "R2";
    chipEn = 1; globalWr = 0; byteWrEn = 1; byteSel = 4'b0010; addr = 8'd3;
    wrData = 36'hF_FFFF_FFFF;
    tick();
    exp = (pat(3) & ~36'h0_0003_FE00) | 36'h0_0003_FE00;
    doRead(3); chkBus("R2 only lane 1 updated", 1, exp);
    chipEn = 1; byteWrEn = 1; byteSel = 4'b1001; addr = 8'd4; wrData = 36'h0;
    tick();
    exp = pat(4) & 36'h0_07FF_FE00;
    doRead(4); chkBus("R2 lanes 0 and 3 cleared", 1, exp);
    idle(1);
  endtask

  task automatic testEmptySelect();
    curReq = "R3";
    chipEn = 1; globalWr = 0; byteWrEn = 1; byteSel = 4'b0000; addr = 8'd2;
    wrData = 36'h0_0000_0000;
    tick(); chkBus("R3 empty select reads", 1, pat(2));
    doRead(2); chkBus("R3 contents unchanged", 1, pat(2));
    idle(1);
  endtask

  task automatic testRaw(input int a, input logic [35:0] d);
    curReq = "R7";
    doWrite(a, d);
    doRead(a);
    if (!pipeMode) chkBus("R7 flow read after write", 1, d);
    else begin
      setIdle(); tick(); chkBus("R7 pipe read after write", 1, d);
    end
    idle(2);
  endtask

  task automatic testPipe();
    curReq = "R5";
    setMode(1);
    doRead(5); chkBus("R5 nothing after edge k", 0, 0);
    curReq = "R6";
    doRead(6); chkBus("R5 beat 1 after edge k+1", 1, pat(5));
    doRead(7); chkBus("R6 pipe beat 2", 1, 36'h1_2345_6789);
    doRead(8); chkBus("R6 pipe beat 3", 1, pat(7));
    curReq = "R8";
    setIdle(); tick(); chkBus("R6 pipe beat 4 during deselect", 1, pat(8));
    tick(); chkBus("R8 pipe release after edge k+1", 0, 0);
    doWrite(20, pat(20));
    doRead(9); chkBus("R8 write slot released", 0, 0);
    setIdle(); tick(); chkBus("R8 read after write slot", 1, pat(9));
    tick(); chkBus("R8 release again", 0, 0);
  endtask

  task automatic testOutEn();
    curReq = "R9";
    doRead(10);
    doRead(11);
    #2 outEn = 0;
    #1 chkBus("R9 released without edge", 0, 0);
    outEn = 1;
    #1 chkBus("R9 restored without edge", 1, pat(10));
    setIdle(); tick();
    tick();
  endtask

  task automatic testSleep();
    curReq = "R10";
    setMode(0);
    doRead(12);
    sleep = 1;
    #1 chkBus("R10 sleep releases at once", 0, 0);
    doWrite(12, 36'h0_0000_0001);
    chkBus("R10 no drive in sleep", 0, 0);
    doRead(13); chkBus("R10 read ignored", 0, 0);
    sleep = 0;
    setIdle(); tick(); chkBus("R10 no read after sleep", 0, 0);
    doRead(12); chkBus("R10 contents kept", 1, pat(12));
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkBus("R11 reset released", 0, 0);
    rstN = 1;
    idle(1);
    chkBus("R11 after reset", 0, 0);
    testFlowBurst();
    testGlobalOverride();
    testLaneWrite();
    testEmptySelect();
    testRaw(30, 36'hA_BCDE_F012);
    testPipe();
    testRaw(31, 36'h5_5AA5_5AA5);
    testOutEn();
    testSleep();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule